// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire I2C bus that behaves like a byte-addressed serial EEPROM. SCL and SDA are brought into the system clock domain through a short synchronizer. From the synchronized levels the block finds START, repeated START, STOP and the clock edges. Only SCL edges and bus conditions move its state machine. The memory array is held in registers, and its size and page size are parameters.

A transaction opens with a device byte. That byte holds a fixed four-bit family code, three bits that must equal the strap inputs, and a direction bit. A write transaction carries two word-address bytes and then data bytes. A read transaction returns data from one persistent address counter. A random read is built from a dummy write followed by a repeated START. Reads and writes advance the counter by different wrap rules: a read wraps across the whole array, a write wraps inside the current page. When the write-protect input is high, the array is read-only.

Top module: `eepSlave`

## Requirements
- R1: The device byte is {4'b1010, strap[2:0], rw}, sent MSB first. The slave pulls SDA low in the ninth clock only when bits 7..1 match. On a mismatch it leaves SDA released for every following clock until the next START, and the counter is unchanged.
- R2: After a write device byte, the slave takes two word-address bytes, high byte first, and acknowledges each. The counter is loaded with the low ADDR bits of {high, low}. High-byte bits above the array width are ignored.
- R3: Each data byte after the word address is acknowledged and stored at the counter. The counter then advances inside its page: the low page bits wrap from PAGE_BYTES-1 to 0 and the upper bits stay the same.
- R4: With wpIn high, data bytes are still acknowledged but the array keeps its old contents. The counter still advances by the write rule.
- R5: A dummy write of the word address, then a repeated START and a read device byte, returns the byte at the loaded address, MSB first.
- R6: A read with no word address returns the byte at the counter. The counter holds the last accessed address plus one and keeps that value across STOP.
- R7: A master ACK (SDA low in the ninth clock) after a read byte makes the slave send the byte at the next address. Reads wrap from address MEM_BYTES-1 to 0.
- R8: A master NACK (SDA high in the ninth clock) ends the read. SDA stays released for any further clocks until START or STOP.
- R9: sdaOe only pulls the line low, and it never changes while SCL is high.
- R10: After reset, sdaOe is 0 and the counter is 0. Array contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| strap | input | 3 | Low three bits of the device address |
| wpIn | input | 1 | Write protect, high blocks array writes |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A wrong counter value shows at the first data byte of the next read, since current-address reads expose the counter directly. A wrong wrap rule shows only when a transfer crosses a page or array boundary, so the bench writes and reads across both. A wrong state shows as a missing or extra acknowledge in the ninth clock of that same byte, or as SDA moving while SCL is high, and the bench checks that second case on every clock.

// File: rtl/eepPkg.sv
package eepPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEVACK,
    ST_AHI,
    ST_AHIACK,
    ST_ALO,
    ST_ALOACK,
    ST_WR,
    ST_WRACK,
    ST_RD,
    ST_RDACK,
    ST_IGNORE
  } eepState_t;

  // strobes from control to datapath, at most one per cycle
  typedef struct packed {
    logic shiftIn;
    logic loadHi;
    logic loadAddr;
    logic wrByte;
    logic fetch;
    logic shiftOut;
  } eepStrobe_t;

endpackage

// File: rtl/eepBusSense.sv
module eepBusSense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);

  logic [SYNC_STAGES-1:0] sclSync;
  logic [SYNC_STAGES-1:0] sdaSync;
  logic sclQ;
  logic sdaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclSync[SYNC_STAGES-1];
      sdaQ    <= sdaSync[SYNC_STAGES-1];
    end
  end

  assign sclLvl  = sclSync[SYNC_STAGES-1];
  assign sdaLvl  = sdaSync[SYNC_STAGES-1];
  assign sclRise = sclLvl & ~sclQ;
  assign sclFall = ~sclLvl & sclQ;
  // data edges while the clock stays high
  assign startEv = sclLvl & sclQ & sdaQ & ~sdaLvl;
  assign stopEv  = sclLvl & sclQ & ~sdaQ & sdaLvl;

endmodule

// File: rtl/eepCtrl.sv
module eepCtrl
  import eepPkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       sdaLvl,
  input  logic [2:0] strap,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output eepStrobe_t strb,
  output logic       sdaOe
);

  eepState_t  state;
  logic [3:0] bitCnt;
  logic       rwBit;
  logic       ackSeen;
  logic       oeNext;
  logic       isRx;
  logic       byteDone;
  logic       matchAddr;
  logic       busEv;

  assign isRx      = (state == ST_DEV) || (state == ST_AHI) ||
                     (state == ST_ALO) || (state == ST_WR);
  assign byteDone  = (bitCnt == 4'd8);
  assign matchAddr = (rxByte[7:1] == {DEV_ID, strap});
  assign busEv     = startEv | stopEv;

  always_comb begin
    strb          = '0;
    strb.shiftIn  = !busEv && sclRise && isRx && !byteDone;
    strb.loadHi   = !busEv && sclFall && (state == ST_AHI) && byteDone;
    strb.loadAddr = !busEv && sclFall && (state == ST_ALO) && byteDone;
    strb.wrByte   = !busEv && sclFall && (state == ST_WR) && byteDone;
    strb.fetch    = !busEv && sclFall &&
                    (((state == ST_DEVACK) && rwBit) || ((state == ST_RDACK) && ackSeen));
    strb.shiftOut = !busEv && sclFall && (state == ST_RD) && !byteDone;
  end

  always_comb begin
    unique case (state)
      ST_DEVACK, ST_AHIACK, ST_ALOACK, ST_WRACK: oeNext = 1'b1;
      ST_RD:                                     oeNext = !txBit;
      default:                                   oeNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      rwBit   <= 1'b0;
      ackSeen <= 1'b0;
      sdaOe   <= 1'b0;
    end else begin
      sdaOe <= oeNext;
      if (startEv) begin
        state  <= ST_DEV;
        bitCnt <= '0;
      end else if (stopEv) begin
        state  <= ST_IDLE;
      end else begin
        if (sclRise && (isRx || state == ST_RD) && !byteDone)
          bitCnt <= bitCnt + 4'd1;
        if (sclRise && state == ST_RDACK)
          ackSeen <= !sdaLvl;
        if (sclFall) begin
          unique case (state)
            ST_DEV: if (byteDone) begin
              if (matchAddr) begin
                state <= ST_DEVACK;
                rwBit <= rxByte[0];
              end else begin
                state <= ST_IGNORE;
              end
            end
            ST_DEVACK: begin
              bitCnt <= '0;
              state  <= rwBit ? ST_RD : ST_AHI;
            end
            ST_AHI:    if (byteDone) state <= ST_AHIACK;
            ST_AHIACK: begin
              bitCnt <= '0;
              state  <= ST_ALO;
            end
            ST_ALO:    if (byteDone) state <= ST_ALOACK;
            ST_ALOACK: begin
              bitCnt <= '0;
              state  <= ST_WR;
            end
            ST_WR:     if (byteDone) state <= ST_WRACK;
            ST_WRACK: begin
              bitCnt <= '0;
              state  <= ST_WR;
            end
            ST_RD:     if (byteDone) state <= ST_RDACK;
            ST_RDACK: begin
              bitCnt <= '0;
              state  <= ackSeen ? ST_RD : ST_IGNORE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_NO_ACK_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (sclFall && !busEv && state == ST_DEV && byteDone && !matchAddr) |-> ##2 !sdaOe); // R1
  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE && $past(state == ST_IGNORE)) |-> !sdaOe); // R8
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (sclFall && !busEv && state == ST_RDACK && !ackSeen) |-> ##2 !sdaOe); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R3

endmodule

// File: rtl/eepData.sv
module eepData
  import eepPkg::*;
#(
  parameter int MEM_BYTES  = 2048,
  parameter int PAGE_BYTES = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  eepStrobe_t strb,
  input  logic       sdaLvl,
  input  logic       wpIn,
  output logic [7:0] rxByte,
  output logic       txBit
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int HW = AW - 8;

  logic [7:0]    mem [MEM_BYTES];
  logic [7:0]    rxSh;
  logic [7:0]    txSh;
  logic [HW-1:0] addrHi;
  logic [AW-1:0] cnt;
  logic [AW-1:0] rdNext;
  logic [AW-1:0] wrNext;
  logic [7:0]    memAtCnt;

  assign memAtCnt = mem[cnt];
  assign rdNext   = cnt + 1'b1;

  generate
    if (PW >= AW) begin : gWrapWhole
      assign wrNext = cnt + 1'b1;
    end else begin : gWrapPage
      logic [PW-1:0] inPage;
      assign inPage = cnt[PW-1:0] + 1'b1;
      assign wrNext = {cnt[AW-1:PW], inPage};

      AST_WR_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrByte |=> cnt[AW-1:PW] == $past(cnt[AW-1:PW])); // R3
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh   <= '0;
      txSh   <= '0;
      addrHi <= '0;
      cnt    <= '0;
    end else begin
      if (strb.shiftIn)  rxSh   <= {rxSh[6:0], sdaLvl};
      if (strb.loadHi)   addrHi <= rxSh[HW-1:0];
      if (strb.loadAddr) cnt    <= {addrHi, rxSh};
      if (strb.wrByte)   cnt    <= wrNext;
      if (strb.fetch) begin
        txSh <= memAtCnt;
        cnt  <= rdNext;
      end
      if (strb.shiftOut) txSh <= {txSh[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrByte && !wpIn) mem[cnt] <= rxSh;
  end

  assign rxByte = rxSh;
  assign txBit  = txSh[7];

  AST_WP_NO_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrByte && wpIn) |=> mem[$past(cnt)] == $past(memAtCnt)); // R4
  AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fetch && cnt == AW'(MEM_BYTES - 1)) |=> cnt == '0); // R7

endmodule

// File: rtl/eepSlave.sv
module eepSlave
  import eepPkg::*;
#(
  parameter int         MEM_BYTES  = 2048,
  parameter int         PAGE_BYTES = 32,
  parameter logic [3:0] DEV_ID     = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  input  logic       wpIn,
  output logic       sdaOe
);

  logic       sclLvl;
  logic       sdaLvl;
  logic       sclRise;
  logic       sclFall;
  logic       startEv;
  logic       stopEv;
  logic [7:0] rxByte;
  logic       txBit;
  eepStrobe_t strb;

  eepBusSense #(.SYNC_STAGES(2)) uSense (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  eepCtrl #(.DEV_ID(DEV_ID)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaLvl(sdaLvl), .strap(strap),
    .rxByte(rxByte), .txBit(txBit), .strb(strb), .sdaOe(sdaOe)
  );

  eepData #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaLvl(sdaLvl), .wpIn(wpIn),
    .rxByte(rxByte), .txBit(txBit)
  );

  AST_OE_STILL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclLvl && $past(sclLvl) && !$past(startEv) && !$past(stopEv)) |-> $stable(sdaOe)); // R9

endmodule

// File: tb/sim_eepSlave.sv
`timescale 1ns/1ps
module sim_eepSlave;

  localparam int MEMB  = 2048;
  localparam int PAGEB = 32;
  localparam int Q     = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sdaOe;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaOe;

  eepSlave #(.MEM_BYTES(MEMB), .PAGE_BYTES(PAGEB), .DEV_ID(4'b1010)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .strap(strap), .wpIn(wp), .sdaOe(sdaOe)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int monBad = 0;
  bit done = 1'b0;
  logic [7:0] refMem [int];
  int refCnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock monitor: the line must not move while SCL is high (R9)
  logic sclP = 1'b1;
  logic oeP = 1'b0;
  always @(negedge clk) begin
    if (rstN && scl && sclP && (sdaOe !== oeP)) monBad++;
    sclP = scl;
    oeP  = sdaOe;
  end

  function automatic int rdStep(input int c);
    return (c + 1) % MEMB;
  endfunction

  function automatic int wrStep(input int c);
    return (c / PAGEB) * PAGEB + (c + 1) % PAGEB;
  endfunction

  function automatic logic [7:0] devByte(input logic [2:0] s, input bit rw);
    return {4'b1010, s, rw};
  endfunction

  task automatic waitQ;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitCycle(input bit mb, output bit seen);
    sdaM = mb; waitQ;
    scl = 1'b1; waitQ;
    seen = sdaLine; waitQ;
    scl = 1'b0; waitQ;
  endtask

  task automatic startCond;
    sdaM = 1'b1; waitQ;
    scl = 1'b1; waitQ;
    sdaM = 1'b0; waitQ;
    scl = 1'b0; waitQ;
  endtask

  task automatic stopCond;
    sdaM = 1'b0; waitQ;
    scl = 1'b1; waitQ;
    sdaM = 1'b1; waitQ; waitQ;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string req);
    bit s;
    for (int i = 7; i >= 0; i--) bitCycle(b[i], s);
    bitCycle(1'b1, s);
    check(s == !expAck, req, s, !expAck);
  endtask

  task automatic readCheck(input bit ack, input string req);
    bit s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, s);
      got[i] = s;
    end
    bitCycle(!ack, s);
    if (refMem.exists(refCnt)) check(got == refMem[refCnt], req, got, refMem[refCnt]);
    refCnt = rdStep(refCnt);
  endtask

  task automatic writeBytes(input logic [7:0] hi, input logic [7:0] lo,
                            input logic [7:0] data [$], input string req);
    startCond;
    sendByte(devByte(3'b101, 1'b0), 1'b1, "R1");
    sendByte(hi, 1'b1, "R2");
    sendByte(lo, 1'b1, "R2");
    refCnt = {hi, lo} % MEMB;
    foreach (data[k]) begin
      sendByte(data[k], 1'b1, req);
      if (!wp) refMem[refCnt] = data[k];
      refCnt = wrStep(refCnt);
    end
    stopCond;
  endtask

  task automatic randomRead(input logic [7:0] hi, input logic [7:0] lo, input int n,
                            input string req);
    startCond;
    sendByte(devByte(3'b101, 1'b0), 1'b1, "R1");
    sendByte(hi, 1'b1, "R2");
    sendByte(lo, 1'b1, "R2");
    refCnt = {hi, lo} % MEMB;
    startCond;
    sendByte(devByte(3'b101, 1'b1), 1'b1, "R5");
    for (int k = 0; k < n; k++) readCheck(k < n - 1, req);
    stopCond;
  endtask

  task automatic currentRead(input int n, input string req);
    startCond;
    sendByte(devByte(3'b101, 1'b1), 1'b1, "R6");
    for (int k = 0; k < n; k++) readCheck(k < n - 1, req);
    stopCond;
  endtask

  task automatic doReset;
    @(negedge clk) rstN = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    refCnt = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bit s;
    int ones;
    doReset;
    check(sdaOe == 1'b0, "R10", sdaOe, 0);

    writeBytes(8'h00, 8'h00, '{8'h11, 8'h22, 8'h33, 8'h44}, "R3");
    doReset;
    check(sdaOe == 1'b0, "R10", sdaOe, 0);
    currentRead(2, "R10");           // counter restarts at 0, contents kept
    currentRead(1, "R6");            // persists across STOP: address 2

    // wrong strap bits, write direction: no ack, following byte ignored
    startCond;
    sendByte(devByte(3'b000, 1'b0), 1'b0, "R1");
    sendByte(8'h12, 1'b0, "R1");
    stopCond;
    // wrong strap bits, read direction: line stays released
    startCond;
    sendByte(devByte(3'b100, 1'b1), 1'b0, "R1");
    ones = 0;
    for (int i = 0; i < 9; i++) begin
      bitCycle(1'b1, s);
      ones += s;
    end
    check(ones == 9, "R1", ones, 9);
    stopCond;
    currentRead(1, "R1");            // counter untouched: address 3

    // high word-address bits above the array are ignored
    writeBytes(8'hF8, 8'h40, '{8'hA0, 8'hA1, 8'hA2, 8'hA3}, "R2");
    // page wrap: 62, 63, 32, 33
    writeBytes(8'h00, 8'h3E, '{8'hB0, 8'hB1, 8'hB2, 8'hB3}, "R3");
    randomRead(8'h00, 8'h3E, 2, "R5");
    currentRead(2, "R6");            // continues at 64
    randomRead(8'h00, 8'h20, 2, "R3");

    // array wrap on sequential read
    writeBytes(8'h07, 8'hFE, '{8'hC0, 8'hC1}, "R3");
    randomRead(8'h07, 8'hFE, 3, "R7");

    // write protect
    wp = 1'b1;
    writeBytes(8'h00, 8'h40, '{8'hEE}, "R4");
    wp = 1'b0;
    currentRead(1, "R4");            // counter advanced to 65
    randomRead(8'h00, 8'h40, 1, "R4");

    // NACK ends the read
    startCond;
    sendByte(devByte(3'b101, 1'b1), 1'b1, "R8");
    readCheck(1'b0, "R8");
    ones = 0;
    for (int i = 0; i < 9; i++) begin
      bitCycle(1'b1, s);
      ones += s;
    end
    check(ones == 9, "R8", ones, 9);
    stopCond;
    currentRead(1, "R8");

    check(monBad == 0, "R9", monBad, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule